// File: doc/BRIEF.md
# Oscillator Control Register Block

This block is the memory-mapped configuration and status front end of a tunable ring-style clock source. Software reaches it through a plain 32-bit single-cycle bus: an address, a write strobe, write data, and read data that follows the address combinationally. The block turns the stored settings into decoded control outputs: an oscillator enable, a four-way speed range, eight 3-bit per-stage drive strengths, an output divider value, phase-output controls and a sleep request.

Each writable field accepts only particular multi-bit codes, or a password alongside the data. This protects the clock source against stray writes. When a write carries a value that is not allowed, the field takes a defined safe setting and a sticky error flag in the status word is set. Software clears the flag by writing a 1 to it. The status word also reports three conditions that come from outside the block: enabled, divider running and stable.

Top module: `osc_ctrl_csr`

## Requirements
- R1: After reset the block has these settings. Enable is on. Range is low (range_o=0). All drive strengths are 0. The divider is 16. Phase enable, shift and flip are all 0. The sleep request is off. The error flag is clear.
- R2: Writing offset 0x0 sets the range from bits 11:0. 0xFA4 selects low (range_o=0), 0xFA5 selects medium (1), 0xFA7 selects high (2) and 0xFA6 selects too-high (3). Any other value selects low and sets the error flag. A read of 0x0 returns the code of the current range in bits 11:0.
- R3: The same write takes bits 23:12 as the enable code. 0xD1E turns the oscillator off and 0xFAB turns it on. Any other value turns it on and sets the error flag. A read returns 0xD1E or 0xFAB in bits 23:12.
- R4: Offsets 0x4 and 0x8 hold stages 0-3 and 4-7. Each register carries four 3-bit fields at bits 2:0, 6:4, 10:8 and 14:12, and drive_o packs stage k at bits 3k+2:3k. A write applies its fields only when bits 31:16 equal 0x9696. With any other password, all four fields of that register become 0 and the error flag is set. A read returns the fields with every other bit 0.
- R5: Offset 0x10 sets the divider. A value 0xAA0+n with n in 0..31 gives div_o=n, where 0 means divide by 32. Any other 12-bit value gives div_o=31 and sets the error flag. A read returns 0xAA0+div_o.
- R6: Offset 0x14 sets the phase controls: shift in bits 1:0, flip in bit 2 and enable in bit 3. These take effect only when bits 11:4 equal 0xAA. Otherwise enable becomes 1, shift and flip become 0, and the error flag is set. A read returns the fields with 0xAA in bits 11:4.
- R7: Offset 0xC takes a 32-bit sleep code. 0xD0A55EED requests sleep and 0x3A7EC0DE wakes. Any other value wakes and sets the error flag. A read returns the code of the current state.
- R8: The error flag is bit 24 of offset 0x18. It stays set until software writes 0x18 with bit 24 = 1. A write with bit 24 = 0 leaves it unchanged.
- R9: A read of 0x18 reports the enabled input at bit 12, the divider-running input at bit 16 and the stable input at bit 31. Writes cannot change these bits.
- R10: Every other address reads as 0, and writes to it change no output and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| st_enabled_i | input | 1 | External enabled status |
| st_div_run_i | input | 1 | External divider-running status |
| st_stable_i | input | 1 | External stable status |
| osc_en_o | output | 1 | Oscillator enable |
| range_o | output | 2 | Range: 0 low, 1 medium, 2 high, 3 too-high |
| drive_o | output | NUM_STAGES*DS_W | Packed per-stage drive strengths |
| div_o | output | 5 | Divider (0 = divide by 32) |
| phase_shift_o | output | 2 | Phase shift |
| phase_flip_o | output | 1 | Phase invert |
| phase_en_o | output | 1 | Phase output enable |
| sleep_o | output | 1 | Sleep request |

## Verification
A wrong fallback in one field decoder shows up one clock after the offending write, in two places: the decoded output port and bit 24 of the status read. It cannot hide behind a later write, because the error flag holds until it is explicitly cleared. The enable code, the range code and the divider field are each swept through all 4096 12-bit values, and the phase password through all 256 values. The bench checks every decoder boundary, including the neighbours of each legal code. Unmapped offsets and status writes are shown to change no port or flag.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    localparam int unsigned OFF_CTRL  = 32'h00;
    localparam int unsigned OFF_DS0   = 32'h04;
    localparam int unsigned OFF_SLEEP = 32'h0C;
    localparam int unsigned OFF_DIV   = 32'h10;
    localparam int unsigned OFF_PHASE = 32'h14;
    localparam int unsigned OFF_STAT  = 32'h18;

    localparam logic [11:0] RNG_LOW   = 12'hFA4;
    localparam logic [11:0] RNG_MED   = 12'hFA5;
    localparam logic [11:0] RNG_HIGH  = 12'hFA7;
    localparam logic [11:0] RNG_OVER  = 12'hFA6;

    localparam logic [11:0] EN_OFF    = 12'hD1E;
    localparam logic [11:0] EN_ON     = 12'hFAB;

    localparam logic [15:0] DS_KEY    = 16'h9696;
    localparam logic [6:0]  DIV_TAG   = 7'h55;
    localparam logic [7:0]  PH_KEY    = 8'hAA;

    localparam logic [31:0] SLP_GO    = 32'hD0A5_5EED;
    localparam logic [31:0] SLP_WAKE  = 32'h3A7E_C0DE;

    localparam int unsigned STAT_EN_BIT  = 12;
    localparam int unsigned STAT_DIV_BIT = 16;
    localparam int unsigned STAT_BAD_BIT = 24;
    localparam int unsigned STAT_STB_BIT = 31;

    typedef enum logic [1:0] {
        RANGE_LOW  = 2'd0,
        RANGE_MED  = 2'd1,
        RANGE_HIGH = 2'd2,
        RANGE_OVER = 2'd3
    } range_e;

    function automatic logic [11:0] range_code(input range_e r);
        case (r)
            RANGE_MED:  return RNG_MED;
            RANGE_HIGH: return RNG_HIGH;
            RANGE_OVER: return RNG_OVER;
            default:    return RNG_LOW;
        endcase
    endfunction

endpackage

// File: rtl/osc_ctrl_fchk.sv
module osc_ctrl_fchk
    import osc_ctrl_pkg::*;
#(
    parameter int DS_W        = 3,
    parameter int STG_PER_REG = 4
) (
    input  logic [31:0]                          wd_i,
    output logic                                 en_o,
    output logic                                 en_bad_o,
    output range_e                               rng_o,
    output logic                                 rng_bad_o,
    output logic [STG_PER_REG-1:0][DS_W-1:0]     ds_o,
    output logic                                 ds_bad_o,
    output logic [4:0]                           div_o,
    output logic                                 div_bad_o,
    output logic [1:0]                           shift_o,
    output logic                                 flip_o,
    output logic                                 ph_en_o,
    output logic                                 ph_bad_o,
    output logic                                 sleep_o,
    output logic                                 sleep_bad_o
);

    localparam int SLOT_W = 4;

    logic ds_ok;
    assign ds_ok    = (wd_i[31:16] == DS_KEY);
    assign ds_bad_o = !ds_ok;

    for (genvar s = 0; s < STG_PER_REG; s++) begin : g_ds
        assign ds_o[s] = ds_ok ? wd_i[s*SLOT_W +: DS_W] : '0;
    end

    always_comb begin
        en_o     = 1'b1;
        en_bad_o = 1'b0;
        if (wd_i[23:12] == EN_OFF) begin
            en_o = 1'b0;
        end else if (wd_i[23:12] != EN_ON) begin
            en_bad_o = 1'b1;
        end

        rng_bad_o = 1'b0;
        case (wd_i[11:0])
            RNG_LOW:  rng_o = RANGE_LOW;
            RNG_MED:  rng_o = RANGE_MED;
            RNG_HIGH: rng_o = RANGE_HIGH;
            RNG_OVER: rng_o = RANGE_OVER;
            default: begin
                rng_o     = RANGE_LOW;
                rng_bad_o = 1'b1;
            end
        endcase

        if (wd_i[11:5] == DIV_TAG) begin
            div_o     = wd_i[4:0];
            div_bad_o = 1'b0;
        end else begin
            div_o     = 5'd31;
            div_bad_o = 1'b1;
        end

        if (wd_i[11:4] == PH_KEY) begin
            shift_o  = wd_i[1:0];
            flip_o   = wd_i[2];
            ph_en_o  = wd_i[3];
            ph_bad_o = 1'b0;
        end else begin
            shift_o  = 2'd0;
            flip_o   = 1'b0;
            ph_en_o  = 1'b1;
            ph_bad_o = 1'b1;
        end

        sleep_o     = (wd_i == SLP_GO);
        sleep_bad_o = (wd_i != SLP_GO) && (wd_i != SLP_WAKE);
    end

endmodule

// File: rtl/osc_ctrl_rdmux.sv
module osc_ctrl_rdmux
    import osc_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_STAGES  = 8,
    parameter int DS_W        = 3,
    parameter int STG_PER_REG = 4
) (
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic                                 en_i,
    input  range_e                               rng_i,
    input  logic [NUM_STAGES-1:0][DS_W-1:0]      ds_i,
    input  logic [4:0]                           div_i,
    input  logic [1:0]                           shift_i,
    input  logic                                 flip_i,
    input  logic                                 ph_en_i,
    input  logic                                 sleep_i,
    input  logic                                 bad_i,
    input  logic                                 st_enabled_i,
    input  logic                                 st_div_run_i,
    input  logic                                 st_stable_i,
    output logic [31:0]                          rdata_o
);

    localparam int DS_REGS = NUM_STAGES / STG_PER_REG;
    localparam int SLOT_W  = 4;

    logic [DS_REGS-1:0][31:0] ds_word;

    for (genvar r = 0; r < DS_REGS; r++) begin : g_word
        always_comb begin
            ds_word[r] = '0;
            for (int s = 0; s < STG_PER_REG; s++) begin
                ds_word[r][s*SLOT_W +: DS_W] = ds_i[r*STG_PER_REG + s];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFF_CTRL)) begin
            rdata_o[23:12] = en_i ? EN_ON : EN_OFF;
            rdata_o[11:0]  = range_code(rng_i);
        end else if (addr_i == ADDR_W'(OFF_SLEEP)) begin
            rdata_o = sleep_i ? SLP_GO : SLP_WAKE;
        end else if (addr_i == ADDR_W'(OFF_DIV)) begin
            rdata_o[11:0] = {DIV_TAG, div_i};
        end else if (addr_i == ADDR_W'(OFF_PHASE)) begin
            rdata_o[11:0] = {PH_KEY, ph_en_i, flip_i, shift_i};
        end else if (addr_i == ADDR_W'(OFF_STAT)) begin
            rdata_o[STAT_EN_BIT]  = st_enabled_i;
            rdata_o[STAT_DIV_BIT] = st_div_run_i;
            rdata_o[STAT_BAD_BIT] = bad_i;
            rdata_o[STAT_STB_BIT] = st_stable_i;
        end else begin
            for (int r = 0; r < DS_REGS; r++) begin
                if (addr_i == ADDR_W'(OFF_DS0 + 4 * r)) rdata_o = ds_word[r];
            end
        end
    end

endmodule

// File: rtl/osc_ctrl_csr.sv
module osc_ctrl_csr
    import osc_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_STAGES = 8,
    parameter int DS_W       = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [31:0]                   wdata_i,
    output logic [31:0]                   rdata_o,
    input  logic                          st_enabled_i,
    input  logic                          st_div_run_i,
    input  logic                          st_stable_i,
    output logic                          osc_en_o,
    output logic [1:0]                    range_o,
    output logic [NUM_STAGES*DS_W-1:0]    drive_o,
    output logic [4:0]                    div_o,
    output logic [1:0]                    phase_shift_o,
    output logic                          phase_flip_o,
    output logic                          phase_en_o,
    output logic                          sleep_o
);

    localparam int STG_PER_REG = 4;
    localparam int DS_REGS     = NUM_STAGES / STG_PER_REG;
    localparam logic [4:0] DIV_RESET = 5'd16;

    typedef struct packed {
        logic                            en;
        range_e                          rng;
        logic [NUM_STAGES-1:0][DS_W-1:0] ds;
        logic [4:0]                      div;
        logic [1:0]                      shift;
        logic                            flip;
        logic                            ph_en;
        logic                            sleep;
        logic                            bad;
    } state_t;

    state_t st_d, st_q;

    logic                             f_en, f_en_bad, f_rng_bad;
    range_e                           f_rng;
    logic [STG_PER_REG-1:0][DS_W-1:0] f_ds;
    logic                             f_ds_bad;
    logic [4:0]                       f_div;
    logic                             f_div_bad;
    logic [1:0]                       f_shift;
    logic                             f_flip, f_ph_en, f_ph_bad;
    logic                             f_sleep, f_sleep_bad;

    osc_ctrl_fchk #(.DS_W(DS_W), .STG_PER_REG(STG_PER_REG)) u_fchk (
        .wd_i        (wdata_i),
        .en_o        (f_en),
        .en_bad_o    (f_en_bad),
        .rng_o       (f_rng),
        .rng_bad_o   (f_rng_bad),
        .ds_o        (f_ds),
        .ds_bad_o    (f_ds_bad),
        .div_o       (f_div),
        .div_bad_o   (f_div_bad),
        .shift_o     (f_shift),
        .flip_o      (f_flip),
        .ph_en_o     (f_ph_en),
        .ph_bad_o    (f_ph_bad),
        .sleep_o     (f_sleep),
        .sleep_bad_o (f_sleep_bad)
    );

    logic hit_ctrl, hit_sleep, hit_div, hit_phase, hit_stat;
    logic [DS_REGS-1:0] hit_ds;

    assign hit_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
    assign hit_sleep = (addr_i == ADDR_W'(OFF_SLEEP));
    assign hit_div   = (addr_i == ADDR_W'(OFF_DIV));
    assign hit_phase = (addr_i == ADDR_W'(OFF_PHASE));
    assign hit_stat  = (addr_i == ADDR_W'(OFF_STAT));

    for (genvar r = 0; r < DS_REGS; r++) begin : g_hit
        assign hit_ds[r] = (addr_i == ADDR_W'(OFF_DS0 + 4 * r));
    end

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (hit_ctrl) begin
                st_d.en  = f_en;
                st_d.rng = f_rng;
                if (f_en_bad || f_rng_bad) st_d.bad = 1'b1;
            end
            for (int r = 0; r < DS_REGS; r++) begin
                if (hit_ds[r]) begin
                    for (int s = 0; s < STG_PER_REG; s++) begin
                        st_d.ds[r*STG_PER_REG + s] = f_ds[s];
                    end
                    if (f_ds_bad) st_d.bad = 1'b1;
                end
            end
            if (hit_sleep) begin
                st_d.sleep = f_sleep;
                if (f_sleep_bad) st_d.bad = 1'b1;
            end
            if (hit_div) begin
                st_d.div = f_div;
                if (f_div_bad) st_d.bad = 1'b1;
            end
            if (hit_phase) begin
                st_d.shift = f_shift;
                st_d.flip  = f_flip;
                st_d.ph_en = f_ph_en;
                if (f_ph_bad) st_d.bad = 1'b1;
            end
            if (hit_stat && wdata_i[STAT_BAD_BIT]) st_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.en    <= 1'b1;
            st_q.rng   <= RANGE_LOW;
            st_q.div   <= DIV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_en_o      = st_q.en;
    assign range_o       = st_q.rng;
    assign drive_o       = st_q.ds;
    assign div_o         = st_q.div;
    assign phase_shift_o = st_q.shift;
    assign phase_flip_o  = st_q.flip;
    assign phase_en_o    = st_q.ph_en;
    assign sleep_o       = st_q.sleep;

    osc_ctrl_rdmux #(
        .ADDR_W(ADDR_W), .NUM_STAGES(NUM_STAGES), .DS_W(DS_W), .STG_PER_REG(STG_PER_REG)
    ) u_rdmux (
        .addr_i       (addr_i),
        .en_i         (st_q.en),
        .rng_i        (st_q.rng),
        .ds_i         (st_q.ds),
        .div_i        (st_q.div),
        .shift_i      (st_q.shift),
        .flip_i       (st_q.flip),
        .ph_en_i      (st_q.ph_en),
        .sleep_i      (st_q.sleep),
        .bad_i        (st_q.bad),
        .st_enabled_i (st_enabled_i),
        .st_div_run_i (st_div_run_i),
        .st_stable_i  (st_stable_i),
        .rdata_o      (rdata_o)
    );

    // R8
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bad && !(we_i && hit_stat && wdata_i[STAT_BAD_BIT])) |=> st_q.bad);

    // R3
    en_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_ctrl && wdata_i[23:12] != EN_OFF) |=> osc_en_o);

    // R4
    ds_wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_ds[0] && wdata_i[31:16] != DS_KEY)
        |=> (drive_o[STG_PER_REG*DS_W-1:0] == '0) && st_q.bad);

    // R5
    div_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_div && wdata_i[11:5] != DIV_TAG) |=> (div_o == 5'd31) && st_q.bad);

    // R2
    rng_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_ctrl && wdata_i[11:4] != 8'hFA) |=> (range_o == 2'd0) && st_q.bad);

    // R10
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !(hit_ctrl || hit_sleep || hit_div || hit_phase || hit_stat || |hit_ds))
        |=> $stable(drive_o) && $stable(osc_en_o) && $stable(range_o) && $stable(div_o)
            && $stable(sleep_o) && $stable(st_q.bad) && $stable(phase_en_o));

endmodule

// File: tb/osc_ctrl_csr_tb.sv
module osc_ctrl_csr_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int NSTG = 8;
    localparam int DSW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic s_en = 1'b0, s_div = 1'b0, s_stb = 1'b0;
    logic osc_en, ph_flip, ph_en, sleep;
    logic [1:0] rng, ph_shift;
    logic [NSTG*DSW-1:0] drive;
    logic [4:0] div;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_ctrl_csr #(.ADDR_W(ADDR_W), .NUM_STAGES(NSTG), .DS_W(DSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .st_enabled_i(s_en), .st_div_run_i(s_div), .st_stable_i(s_stb),
        .osc_en_o(osc_en), .range_o(rng), .drive_o(drive), .div_o(div),
        .phase_shift_o(ph_shift), .phase_flip_o(ph_flip), .phase_en_o(ph_en), .sleep_o(sleep)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clr_bad();
        wr(12'h018, 32'h0100_0000);
    endtask

    function automatic logic bad_of(input logic [31:0] s);
        return s[24];
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 en", {31'b0, osc_en}, 32'd1);
        check("R1 range", {30'b0, rng}, 32'd0);
        check("R1 drive", {8'b0, drive}, 32'd0);
        check("R1 div", {27'b0, div}, 32'd16);
        check("R1 phase", {28'b0, ph_en, ph_flip, ph_shift}, 32'd0);
        check("R1 sleep", {31'b0, sleep}, 32'd0);
        rd(12'h018, r); check("R1 bad", {31'b0, bad_of(r)}, 32'd0);
        rd(12'h010, r); check("R1 div read", r, 32'h0000_0AB0);

        // R2 range sweep
        for (int v = 0; v < 4096; v++) begin
            logic [1:0] er; logic eb;
            clr_bad();
            wr(12'h000, {8'h0, 12'hFAB, 12'(v)});
            case (v)
                12'hFA4: begin er = 2'd0; eb = 1'b0; end
                12'hFA5: begin er = 2'd1; eb = 1'b0; end
                12'hFA7: begin er = 2'd2; eb = 1'b0; end
                12'hFA6: begin er = 2'd3; eb = 1'b0; end
                default: begin er = 2'd0; eb = 1'b1; end
            endcase
            check("R2 range", {30'b0, rng}, {30'b0, er});
            rd(12'h018, r); check("R2 bad", {31'b0, bad_of(r)}, {31'b0, eb});
        end
        wr(12'h000, {8'h0, 12'hFAB, 12'hFA7});
        rd(12'h000, r); check("R2 readback", r, 32'h00FA_BFA7);

        // R3 enable sweep
        for (int v = 0; v < 4096; v++) begin
            clr_bad();
            wr(12'h000, {8'h0, 12'(v), 12'hFA4});
            check("R3 en", {31'b0, osc_en}, {31'b0, (v != 12'hD1E)});
            rd(12'h018, r);
            check("R3 bad", {31'b0, bad_of(r)}, {31'b0, (v != 12'hD1E && v != 12'hFAB)});
        end
        wr(12'h000, {8'h0, 12'hD1E, 12'hFA5});
        rd(12'h000, r); check("R3 readback", r, 32'h00D1_EFA5);

        // R4 drive strengths
        lcg = 32'h1234_5678;
        for (int i = 0; i < 64; i++) begin
            logic [15:0] key; logic [11:0] f; logic ok; int reg_i;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            reg_i = i % 2;
            key = (i % 4 < 2) ? 16'h9696 : ((i % 8 == 2) ? 16'h9697 : lcg[31:16]);
            ok = (key == 16'h9696);
            f = lcg[11:0];
            clr_bad();
            wr(12'(4 + 4 * reg_i), {key, 1'b1, f[11:9], 1'b1, f[8:6], 1'b1, f[5:3], 1'b1, f[2:0]});
            check("R4 fields", {20'b0, drive[reg_i*12 +: 12]}, ok ? {20'b0, f} : 32'd0);
            rd(12'(4 + 4 * reg_i), r);
            check("R4 readback", r, ok ? {17'b0, f[11:9], 1'b0, f[8:6], 1'b0, f[5:3], 1'b0, f[2:0]} : 32'd0);
            rd(12'h018, r); check("R4 bad", {31'b0, bad_of(r)}, {31'b0, !ok});
        end
        wr(12'h004, 32'h9696_7654);
        wr(12'h008, 32'h9696_3210);
        check("R4 packing", {8'b0, drive}, {8'b0, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4});

        // R5 divider sweep
        for (int v = 0; v < 4096; v++) begin
            logic ok;
            ok = (v >= 12'hAA0 && v <= 12'hABF);
            clr_bad();
            wr(12'h010, 32'(v));
            check("R5 div", {27'b0, div}, ok ? 32'(v - 12'hAA0) : 32'd31);
            rd(12'h018, r); check("R5 bad", {31'b0, bad_of(r)}, {31'b0, !ok});
        end
        wr(12'h010, 32'h0000_0AA0);
        rd(12'h010, r); check("R5 readback zero", r, 32'h0000_0AA0);

        // R6 phase password sweep
        for (int k = 0; k < 256; k++) begin
            logic [3:0] fv; logic ok;
            fv = 4'(k * 7 + 3);
            ok = (k == 8'hAA);
            clr_bad();
            wr(12'h014, {20'b0, 8'(k), fv});
            check("R6 phase", {28'b0, ph_en, ph_flip, ph_shift}, ok ? {28'b0, fv} : 32'd8);
            rd(12'h018, r); check("R6 bad", {31'b0, bad_of(r)}, {31'b0, !ok});
        end
        wr(12'h014, 32'h0000_0AA6);
        rd(12'h014, r); check("R6 readback", r, 32'h0000_0AA6);

        // R7 sleep codes
        clr_bad();
        wr(12'h00C, 32'hD0A5_5EED);
        check("R7 sleep", {31'b0, sleep}, 32'd1);
        rd(12'h00C, r); check("R7 readback", r, 32'hD0A5_5EED);
        rd(12'h018, r); check("R7 good bad", {31'b0, bad_of(r)}, 32'd0);
        wr(12'h00C, 32'hD0A5_5EEC);
        check("R7 invalid wakes", {31'b0, sleep}, 32'd0);
        rd(12'h018, r); check("R7 invalid bad", {31'b0, bad_of(r)}, 32'd1);
        clr_bad();
        wr(12'h00C, 32'hD0A5_5EED);
        wr(12'h00C, 32'h3A7E_C0DE);
        check("R7 wake", {31'b0, sleep}, 32'd0);
        rd(12'h018, r); check("R7 wake bad", {31'b0, bad_of(r)}, 32'd0);

        // R8 sticky flag
        wr(12'h010, 32'h0000_0123);
        wr(12'h018, 32'hFEFF_FFFF);
        rd(12'h018, r); check("R8 write0 keeps", {31'b0, bad_of(r)}, 32'd1);
        wr(12'h010, 32'h0000_0AA5);
        rd(12'h018, r); check("R8 good write keeps", {31'b0, bad_of(r)}, 32'd1);
        wr(12'h018, 32'h0100_0000);
        rd(12'h018, r); check("R8 w1c", {31'b0, bad_of(r)}, 32'd0);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h018, r); check("R8 no set", {31'b0, bad_of(r)}, 32'd0);

        // R9 status inputs
        for (int m = 0; m < 8; m++) begin
            logic [31:0] e;
            s_en = m[0]; s_div = m[1]; s_stb = m[2];
            e = '0; e[12] = m[0]; e[16] = m[1]; e[31] = m[2];
            rd(12'h018, r); check("R9 status", r, e);
        end

        // R10 unmapped
        begin
            logic [NSTG*DSW-1:0] d0; logic [4:0] v0; logic e0; logic [1:0] g0;
            d0 = drive; v0 = div; e0 = osc_en; g0 = rng;
            for (int a = 0; a < 16; a++) begin
                logic [ADDR_W-1:0] ua;
                ua = (a < 8) ? 12'(12'h01C + 4 * a) : 12'(12'h001 + 4 * (a - 8) + (a % 3));
                wr(ua, 32'hFFFF_FFFF);
                rd(ua, r); check("R10 read zero", r, 32'd0);
            end
            check("R10 drive", {8'b0, drive}, {8'b0, d0});
            check("R10 div", {27'b0, div}, {27'b0, v0});
            check("R10 en rng", {29'b0, osc_en, rng}, {29'b0, e0, g0});
            rd(12'h018, r); check("R10 bad", {31'b0, bad_of(r)}, 32'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule